// File: doc/BRIEF.md
# Dual-Mode Rewindable Dual-Clock FIFO

This block is a first-in first-out buffer that sits between a write clock domain and a read clock domain. Words enter on the write clock while the write enable is low and leave on the read clock while the read enable is low. Each pointer crosses to the other domain in Gray code through a two-stage synchroniser, and each side works out its own flags from its own pointer and the synchronised copy of the other one.

The read side can work in one of two ways, chosen by a mode pin that is sampled while the master reset is held low. In standard mode every word, the first one included, has to be requested, and the flags report "empty" and "full". In fall-through mode the oldest word is placed on the output without a request, and the flags report "output valid" and "input ready". Both modes also drive almost-empty, almost-full and half-full flags. The almost-empty and almost-full thresholds come from two offset registers that are loaded through a small parallel port on the write clock.

The retransmit input rewinds the read pointer to memory location zero, so the data can be read again from the start. A short setup phase follows, and the read-side flag marks it. A partial reset clears the pointers and the data path but keeps the selected mode and the offset values. The write clock and the read clock may be the same clock or two unrelated clocks.

Top module: `rtfifo_top`

## Requirements
- R1: While the master reset `mrst_n` is low, both pointers return to location zero and the FIFO holds no words. `pae_n` is low, `paf_n` is high, `hf_n` is high and `dout` is all zeroes.
- R2: The level of `mode_fwft` while `mrst_n` is low selects the mode: 0 selects standard mode, 1 selects fall-through mode. In reset, standard mode drives `rd_flag_n` (empty, low = empty) low and `wr_flag_n` (full, low = full) high. Fall-through mode drives `rd_flag_n` (output valid, low = valid) high and `wr_flag_n` (input ready, high = no room) low.
- R3: The partial reset `prst_n` sets the same pointer, flag and `dout` levels as R1. It keeps the mode and both offset values.
- R4: In standard mode, `rd_flag_n` goes high after the third rising read-clock edge that follows the write-clock edge storing a word into an empty FIFO. `dout` changes only on a rising read-clock edge with `ren_n` low and `rd_flag_n` high, and it then shows the oldest unread word.
- R5: In fall-through mode, the first word written into an empty FIFO appears on `dout`, with `rd_flag_n` low, after the third rising read-clock edge. No read request is needed. Each later word needs `ren_n` low on a read-clock edge. After the last word has been taken, `rd_flag_n` returns high.
- R6: The memory holds DEPTH words; in fall-through mode one more word can wait on `dout`. While the FIFO is full, `wr_flag_n` shows full (low in standard mode, high in fall-through mode), and a write is ignored. After a read from a full FIFO the full indication clears following the second rising write-clock edge.
- R7: A read request while the FIFO is empty is ignored: `dout` and the read pointer keep their values, and no word is lost.
- R8: `pae_n` is low when the number of words held in memory is at or below the empty offset. In fall-through mode the word already on `dout` is not counted.
- R9: `paf_n` is low when the free space in memory (DEPTH minus the word count) is at or below the full offset.
- R10: `hf_n` is low when more than DEPTH/2 words are held in memory.
- R11: A write-clock edge with `off_we` high loads `off_val` into the empty offset when `off_sel` is 0, or into the full offset when `off_sel` is 1. A master reset returns both offsets to their parameter defaults.
- R12: Retransmit setup starts on a rising read-clock edge with `rt_n` low while `ren_n` and `wen_n` are high. The read pointer goes to location zero. In standard mode `rd_flag_n` is low after that edge and the next two edges, and it goes high after the third edge. Reading then starts from location zero again. A retransmit only replays correctly while no more than DEPTH words have been written since the last reset.
- R13: In fall-through mode, `rd_flag_n` is high after the retransmit edge and the next two edges. After the third edge it goes low, and at the same moment the word at location zero appears on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Asynchronous master reset, active low; samples the mode |
| prst_n | input | 1 | Asynchronous partial reset, active low; keeps mode and offsets |
| mode_fwft | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| ren_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Retransmit request, active low |
| off_we | input | 1 | Offset load strobe (write clock) |
| off_sel | input | 1 | Offset select: 0 empty offset, 1 full offset |
| off_val | input | AW+1 | Offset value to load |
| dout | output | DW | Output data register |
| rd_flag_n | output | 1 | Empty flag (standard) or output-valid flag (fall-through) |
| wr_flag_n | output | 1 | Full flag (standard) or input-ready flag (fall-through) |
| pae_n | output | 1 | Almost-empty, active low |
| paf_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
A single word written into an empty FIFO is tracked one edge at a time. This separates the three-edge synchroniser latency from any off-by-one in the empty or valid flag, and it shows whether fall-through happens without a request. A burst past capacity, followed by one read, separates dropped writes from stored ones and measures the two-edge release of the full flag. Draining and refilling one word at a time, with a settling gap after each step, takes the occupancy through every count. This reaches each almost-empty, almost-full and half-full threshold under both the default and the reloaded offsets. Retransmit is tried in both modes after partial reads, which separates a rewind to location zero from a replay that resumes at the current read point.

// File: rtl/rtfifo_pkg.sv
package rtfifo_pkg;
  // Gray/binary conversion on a 32-bit container; narrower values are zero-extended.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = g[i] ^ b[i+1];
    return b;
  endfunction
endpackage

// File: rtl/rtfifo_ram.sv
module rtfifo_ram #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtfifo_sync.sv
module rtfifo_sync #(
  parameter int W = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) s[i] <= '0;
    end else begin
      s[0] <= d;
      for (int i = 1; i < STAGES; i++) s[i] <= s[i-1];
    end
  end

  assign q = s[STAGES-1];
endmodule

// File: rtl/rtfifo_wr.sv
module rtfifo_wr #(
  parameter int DEPTH = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          mode_i,
  input  logic          wen_n,
  input  logic          off_we,
  input  logic          off_sel,
  input  logic [PW-1:0] off_val,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          fwft_q,
  output logic [PW-1:0] ae_off,
  output logic [PW-1:0] af_off,
  output logic          wr_flag_n,
  output logic          paf_n,
  output logic          hf_n
);
  import rtfifo_pkg::*;

  logic [PW-1:0] wbin, rbin, wcnt, wbin_nxt, cnt_nxt;
  logic          full;

  always_comb begin
    rbin     = PW'(gray2bin(32'(rgray_s)));
    wcnt     = wbin - rbin;
    full     = (wcnt == PW'(DEPTH));
    we       = !wen_n && !full;
    wbin_nxt = wbin + PW'(we);
    cnt_nxt  = wbin_nxt - rbin;
  end

  assign waddr     = wbin[AW-1:0];
  assign wr_flag_n = fwft_q ? full : !full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      paf_n <= 1'b1;
      hf_n  <= 1'b1;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= PW'(bin2gray(32'(wbin_nxt)));
      paf_n <= !((PW'(DEPTH) - cnt_nxt) <= af_off);
      hf_n  <= !(cnt_nxt > PW'(DEPTH / 2));
    end
  end

  // Mode and offsets survive a partial reset; only the master reset touches them.
  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      fwft_q <= mode_i;
      ae_off <= PW'(AE_DEF);
      af_off <= PW'(AF_DEF);
    end else if (off_we) begin
      if (off_sel) af_off <= off_val;
      else         ae_off <= off_val;
    end
  end
endmodule

// File: rtl/rtfifo_rd.sv
module rtfifo_rd #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          mode_i,
  input  logic          ren_n,
  input  logic          rt_n,
  input  logic          wen_n,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] ae_off,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          fwft_q,
  output logic [DW-1:0] dout,
  output logic          rd_flag_n,
  output logic          pae_n
);
  import rtfifo_pkg::*;

  localparam logic [1:0] HOLD = 2'd2;

  logic [PW-1:0] rbin, wbin, rbin_nxt;
  logic [1:0]    hold;
  logic          ok, busy, rt_go, pop;

  always_comb begin
    wbin  = PW'(gray2bin(32'(wgray_s)));
    busy  = (hold != 2'd0);
    rt_go = !rt_n && ren_n && wen_n && !busy;
    if (fwft_q) pop = (rbin != wbin) && (!ok || !ren_n) && !busy && !rt_go;
    else        pop = !ren_n && ok && !busy;
    rbin_nxt = rt_go ? '0 : rbin + PW'(pop);
  end

  assign raddr     = rbin[AW-1:0];
  assign rd_flag_n = fwft_q ? !ok : ok;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      hold  <= 2'd0;
      ok    <= 1'b0;
      dout  <= '0;
      pae_n <= 1'b0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= PW'(bin2gray(32'(rbin_nxt)));
      if (rt_go)     hold <= HOLD;
      else if (busy) hold <= hold - 2'd1;
      if (pop) dout <= mem_q;
      if (rt_go || busy) ok <= 1'b0;
      else if (fwft_q) begin
        if (pop)         ok <= 1'b1;
        else if (!ren_n) ok <= 1'b0;
      end else           ok <= (rbin_nxt != wbin);
      pae_n <= !((wbin - rbin_nxt) <= ae_off);
    end
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) fwft_q <= mode_i;
  end
endmodule

// File: rtl/rtfifo_top.sv
module rtfifo_top #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_fwft,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          ren_n,
  input  logic          rt_n,
  input  logic          off_we,
  input  logic          off_sel,
  input  logic [PW-1:0] off_val,
  output logic [DW-1:0] dout,
  output logic          rd_flag_n,
  output logic          wr_flag_n,
  output logic          pae_n,
  output logic          paf_n,
  output logic          hf_n
);
  logic          rst_any;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s, ae_off, af_off;
  logic [AW-1:0] waddr, raddr;
  logic          we, fwft_w, fwft_r;
  logic [DW-1:0] mem_q;

  assign rst_any = mrst_n & prst_n;

  rtfifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din), .raddr(raddr), .rdata(mem_q)
  );

  rtfifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_any), .d(wgray), .q(wgray_s));
  rtfifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_any), .d(rgray), .q(rgray_s));

  rtfifo_wr #(.DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .wclk(wclk), .rst_n(rst_any), .mrst_n(mrst_n), .mode_i(mode_fwft), .wen_n(wen_n),
    .off_we(off_we), .off_sel(off_sel), .off_val(off_val), .rgray_s(rgray_s),
    .wgray(wgray), .waddr(waddr), .we(we), .fwft_q(fwft_w), .ae_off(ae_off),
    .af_off(af_off), .wr_flag_n(wr_flag_n), .paf_n(paf_n), .hf_n(hf_n)
  );

  rtfifo_rd #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_any), .mrst_n(mrst_n), .mode_i(mode_fwft), .ren_n(ren_n),
    .rt_n(rt_n), .wen_n(wen_n), .wgray_s(wgray_s), .ae_off(ae_off), .mem_q(mem_q),
    .raddr(raddr), .rgray(rgray), .fwft_q(fwft_r), .dout(dout),
    .rd_flag_n(rd_flag_n), .pae_n(pae_n)
  );
endmodule

// File: rtl/rtfifo_chk.sv
module rtfifo_chk #(
  parameter int DW = 8,
  parameter int PW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          wen_n,
  input logic          ren_n,
  input logic          rt_n,
  input logic          wr_flag_n,
  input logic          rd_flag_n,
  input logic          pae_n,
  input logic          paf_n,
  input logic          hf_n,
  input logic          fwft_w,
  input logic          fwft_r,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [DW-1:0] dout
);
  logic rst_ok;
  assign rst_ok = mrst_n && prst_n;

  AST_RST_WSIDE: assert property (@(posedge wclk)
    !rst_ok |-> (paf_n && hf_n && wgray == '0)) else $error("AST_RST_WSIDE"); // R1 R3

  AST_RST_RSIDE: assert property (@(posedge rclk)
    !rst_ok |-> (!pae_n && dout == '0 && rgray == '0 && (fwft_r ? rd_flag_n : !rd_flag_n)))
    else $error("AST_RST_RSIDE"); // R2

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_ok)
    (!wen_n && (fwft_w ? wr_flag_n : !wr_flag_n)) |=> $stable(wgray))
    else $error("AST_NO_OVERFLOW"); // R6

  AST_EMPTY_READ: assert property (@(posedge rclk) disable iff (!rst_ok)
    (!fwft_r && !ren_n && rt_n && !rd_flag_n) |=> ($stable(rgray) && $stable(dout)))
    else $error("AST_EMPTY_READ"); // R7

  AST_RT_SETUP: assert property (@(posedge rclk) disable iff (!rst_ok)
    (!rt_n && ren_n && wen_n) |=> (rgray == '0 && (fwft_r ? rd_flag_n : !rd_flag_n)))
    else $error("AST_RT_SETUP"); // R12 R13
endmodule

bind rtfifo_top rtfifo_chk #(.DW(DW), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .wen_n(wen_n),
  .ren_n(ren_n), .rt_n(rt_n), .wr_flag_n(wr_flag_n), .rd_flag_n(rd_flag_n),
  .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n), .fwft_w(fwft_w), .fwft_r(fwft_r),
  .wgray(wgray), .rgray(rgray), .dout(dout)
);

// File: tb/tb_rtfifo_top.sv
module tb_rtfifo_top;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic mrst_n = 1'b1, prst_n = 1'b1, mode_fwft = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1, rt_n = 1'b1;
  logic off_we = 1'b0, off_sel = 1'b0;
  logic [PW-1:0] off_val = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic rd_flag_n, wr_flag_n, pae_n, paf_n, hf_n;

  int checks = 0, bad = 0;
  int q[$];
  int hist[$];
  int ae = 2, af = 2, last_out = 0;

  always #2 clk = ~clk;

  rtfifo_top #(.DW(DW), .DEPTH(DEPTH)) dut (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_fwft(mode_fwft),
    .wen_n(wen_n), .din(din), .ren_n(ren_n), .rt_n(rt_n), .off_we(off_we),
    .off_sel(off_sel), .off_val(off_val), .dout(dout), .rd_flag_n(rd_flag_n),
    .wr_flag_n(wr_flag_n), .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // standard-mode flag model on a settled FIFO
  task automatic flags_std();
    int c;
    c = q.size();
    eq("R8 pae_n", int'(pae_n), int'(!(c <= ae)));
    eq("R9 paf_n", int'(paf_n), int'(!((DEPTH - c) <= af)));
    eq("R10 hf_n", int'(hf_n), int'(!(c > DEPTH / 2)));
    eq("R4 rd_flag_n", int'(rd_flag_n), int'(c > 0));
    eq("R6 wr_flag_n", int'(wr_flag_n), int'(c != DEPTH));
  endtask

  task automatic wr(input int v);
    din = DW'(v); wen_n = 1'b0; step(); wen_n = 1'b1;
    hist.push_back(v);
    if (q.size() < DEPTH) q.push_back(v);
  endtask

  task automatic rd_std(input string tag);
    ren_n = 1'b0; step(); ren_n = 1'b1;
    if (q.size() > 0) last_out = q.pop_front();
    eq(tag, int'(dout), last_out);
  endtask

  task automatic rd_fw(input string tag, input int exp);
    ren_n = 1'b0; step(); ren_n = 1'b1;
    eq(tag, int'(dout), exp);
  endtask

  task automatic ld(input bit sel, input int v);
    off_sel = sel; off_val = PW'(v); off_we = 1'b1; step(); off_we = 1'b0;
    if (sel) af = v; else ae = v;
  endtask

  task automatic do_mrst(input bit m);
    mode_fwft = m; mrst_n = 1'b0; step(2); mrst_n = 1'b1; step();
    q.delete(); hist.delete(); ae = 2; af = 2; last_out = 0;
  endtask

  task automatic do_prst();
    prst_n = 1'b0; step(2); prst_n = 1'b1; step();
    q.delete(); hist.delete(); last_out = 0;
  endtask

  task automatic reset_levels(input string tag, input bit fw);
    eq({tag, " dout"}, int'(dout), 0);
    eq({tag, " pae_n"}, int'(pae_n), 0);
    eq({tag, " paf_n"}, int'(paf_n), 1);
    eq({tag, " hf_n"}, int'(hf_n), 1);
    eq({tag, " R2 rd_flag_n"}, int'(rd_flag_n), fw ? 1 : 0);
    eq({tag, " R2 wr_flag_n"}, int'(wr_flag_n), fw ? 0 : 1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    #400000;
    checks++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    #1 mrst_n = 1'b0;
    // R1 R2: master reset into standard mode
    do_mrst(1'b0);
    reset_levels("R1", 1'b0);
    flags_std();

    // R4: first-word latency in standard mode, no fall-through
    wr(8'hA5);
    eq("R4 e0", int'(rd_flag_n), 0); step();
    eq("R4 e1", int'(rd_flag_n), 0); step();
    eq("R4 e2", int'(rd_flag_n), 0); step();
    eq("R4 e3", int'(rd_flag_n), 1);
    eq("R4 no fall-through", int'(dout), 0);
    rd_std("R4 data");
    eq("R4 empty again", int'(rd_flag_n), 0);
    // R7: read on empty is ignored
    rd_std("R7 empty read dout");
    wr(8'hB6); step(4);
    rd_std("R7 no pointer slip");

    // R6: fill past capacity; extra writes dropped
    for (int i = 0; i < 18; i++) wr(16 + i);
    step(4);
    flags_std();
    ren_n = 1'b0; step(); ren_n = 1'b1;
    last_out = q.pop_front();
    eq("R6 read from full", int'(dout), last_out);
    eq("R6 full r0", int'(wr_flag_n), 0); step();
    eq("R6 full r1", int'(wr_flag_n), 0); step();
    eq("R6 full r2", int'(wr_flag_n), 1);
    wr(8'h40); step(4);
    flags_std();
    // R8 R9 R10: sweep every count while draining
    for (int i = 0; i < DEPTH; i++) begin
      rd_std("R6 drain data");
      step(4);
      flags_std();
    end
    rd_std("R7 read past empty");

    // R11: reload offsets, sweep every count while filling
    ld(1'b0, 5); ld(1'b1, 4);
    step(4);
    flags_std();
    for (int i = 0; i < DEPTH; i++) begin
      wr(i); step(4); flags_std();
    end

    // R3: partial reset keeps mode and offsets
    do_prst();
    reset_levels("R3", 1'b0);
    for (int i = 0; i < 7; i++) begin
      wr(8'h60 + i); step(4); flags_std();
    end

    // R12: retransmit in standard mode
    do_prst();
    for (int i = 0; i < 4; i++) wr(8'h80 + i);
    step(4);
    rd_std("R12 pre"); rd_std("R12 pre");
    rt_n = 1'b0; step(); rt_n = 1'b1;
    eq("R12 t0", int'(rd_flag_n), 0); step();
    eq("R12 t1", int'(rd_flag_n), 0); step();
    eq("R12 t2", int'(rd_flag_n), 0); step();
    eq("R12 t3", int'(rd_flag_n), 1);
    q = hist;
    for (int i = 0; i < 4; i++) rd_std("R12 replay");

    // R2 R11: master reset into fall-through mode, defaults restored
    do_mrst(1'b1);
    reset_levels("R1", 1'b1);

    // R5: fall-through latency
    wr(8'hC3);
    eq("R5 e0", int'(rd_flag_n), 1); step();
    eq("R5 e1", int'(rd_flag_n), 1); step();
    eq("R5 e2", int'(rd_flag_n), 1); step();
    eq("R5 e3 flag", int'(rd_flag_n), 0);
    eq("R5 e3 data", int'(dout), 8'hC3);
    wr(8'hD4); wr(8'hE5); wr(8'hF6); step(5);
    eq("R11 default empty offset", int'(pae_n), 1);
    eq("R5 held without read", int'(dout), 8'hC3);
    rd_fw("R5 next", 8'hD4);
    rd_fw("R5 next", 8'hE5);
    rd_fw("R5 next", 8'hF6);
    rd_fw("R7 fwft empty dout", 8'hF6);
    eq("R5 drained", int'(rd_flag_n), 1);

    // R6: fall-through capacity is DEPTH+1
    for (int i = 0; i < 18; i++) wr(8'h50 + i);
    step(5);
    eq("R6 input ready high", int'(wr_flag_n), 1);
    eq("R6 head", int'(dout), 8'h50);
    for (int i = 1; i <= DEPTH; i++) rd_fw("R6 fwft data", 8'h50 + i);
    rd_fw("R6 last kept", 8'h50 + DEPTH);
    eq("R6 dropped extra", int'(rd_flag_n), 1);

    // R13: retransmit in fall-through mode
    do_mrst(1'b1);
    wr(8'h90); wr(8'h91); wr(8'h92); step(5);
    eq("R13 head", int'(dout), 8'h90);
    rd_fw("R13 pre", 8'h91);
    rt_n = 1'b0; step(); rt_n = 1'b1;
    eq("R13 t0", int'(rd_flag_n), 1); step();
    eq("R13 t1", int'(rd_flag_n), 1); step();
    eq("R13 t2", int'(rd_flag_n), 1); step();
    eq("R13 t3 flag", int'(rd_flag_n), 0);
    eq("R13 t3 data", int'(dout), 8'h90);
    rd_fw("R13 replay", 8'h91);
    rd_fw("R13 replay", 8'h92);

    summary();
    $finish;
  end
endmodule